// File: doc/BRIEF.md
# Serial Flash Single-Byte Read Sequencer

This block fetches one byte from a serial NOR flash. Software first loads the flash address into a set of byte registers. It then selects the lane widths in a bus-mode register, optionally sets a fast-read bit, and sets the start bit of the command register. The sequencer runs one complete transfer with chip select held low. It shifts out an 8-bit opcode on one line, then the address on one, two or four lines. It idles for a dummy count that depends on the chosen widths. Finally it gathers the data byte on one, two or four lines and places it in a read-data register.

The flash pins are a serial clock, an active-low chip select and four bidirectional IO lines. The IO lines carry only the opcode and the address. The sequencer stops driving them when the address ends, so the flash can drive the data. One SCK period lasts two system clocks: one clock with SCK low, then one clock with SCK high. The sequencer changes its outputs while SCK is low. It samples the IO lines on the system clock edge that raises SCK.

Top module: `flashReadSeq`

## Requirements
- R1: After reset, every register reads 0, csN is 1 and sck is 0.
- R2: The opcode always goes out on io0, most significant bit first. The opcode is chosen in this priority order: bus-mode bit 2 (four-lane data) takes the byte at register offset 8; bus-mode bit 0 (two-lane data) takes offset 7; otherwise offset 6 bit 0 selects 0x0B when it is 1 and 0x03 when it is 0.
- R3: The address follows the opcode, most significant byte first. The byte at offset 3 holds bits 23:16, offset 2 holds bits 15:8 and offset 1 holds bits 7:0. When bus-mode bit 4 is set, the byte at offset 4 (bits 31:24) is sent before them. The address uses four lanes only when bits 3 and 2 are both set. It uses two lanes only when bits 1 and 0 are both set and bit 2 is clear. In every other case it uses io0 alone. On several lanes, the highest-numbered lane carries the most significant bit.
- R4: Dummy SCK periods: with one-lane data, 8 if fast-read is set and 0 if it is clear. With two- or four-lane data, the count depends only on the address lanes: 8 for one lane, 4 for two lanes, 6 for four lanes.
- R5: The data byte is assembled most significant bit first over 8, 4 or 2 SCK periods. One-lane data is read on io1, two-lane data on io1:io0 and four-lane data on io3:io0. The byte is readable at offset 9.
- R6: Writing 1 to bit 0 of offset 0 starts the access. That bit then reads 1 until the byte is stored and clears by itself. csN is low for exactly 2N system clocks, where N is the number of SCK periods, starting one clock after the write.
- R7: The sequencer leaves all IO lines undriven during the dummy and data phases.
- R8: Register writes made while an access is running have no effect.
- R9: Writing offset 0 with bit 0 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rstN | input | 1 | active-low asynchronous reset |
| regWrEn | input | 1 | register write strobe |
| regAddr | input | 4 | register offset |
| regWrData | input | 8 | write data |
| regRdData | output | 8 | read data of the selected register (combinational) |
| sck | output | 1 | flash serial clock |
| csN | output | 1 | flash chip select, active low |
| sio | inout | 4 | flash IO lines |

## Verification
Two cases are hard to reach from the ports. The first is a register write that lands in the middle of a running access. The second is the data hand-off, where the flash must drive exactly in the SCK period after the last dummy clock. For the first, the bench raises a write to the address byte while the transfer is running, at a fixed cycle that it counts from the start. It reads the register back after the transfer ends. For the second, a behavioural flash model counts SCK rising edges and places data on the bus only at falling edges past the opcode, address and dummy counts that the bench expects. A wrong dummy count or lane choice therefore yields a wrong byte, a wrong captured address or a wrong edge count. The bench also covers the case where both data-width bits are set, to test the priority rule.

// File: rtl/flashSeqPkg.sv
package flashSeqPkg;
  localparam int REG_AW = 4;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int CNT_W  = 6;

  localparam logic [REG_AW-1:0] OFS_CMD   = 4'd0;
  localparam logic [REG_AW-1:0] OFS_ADR0  = 4'd1;
  localparam logic [REG_AW-1:0] OFS_ADR1  = 4'd2;
  localparam logic [REG_AW-1:0] OFS_ADR2  = 4'd3;
  localparam logic [REG_AW-1:0] OFS_ADR3  = 4'd4;
  localparam logic [REG_AW-1:0] OFS_BUS   = 4'd5;
  localparam logic [REG_AW-1:0] OFS_FAST  = 4'd6;
  localparam logic [REG_AW-1:0] OFS_OPC2  = 4'd7;
  localparam logic [REG_AW-1:0] OFS_OPC4  = 4'd8;
  localparam logic [REG_AW-1:0] OFS_RDATA = 4'd9;

  typedef enum logic [2:0] {PH_IDLE, PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA} phaseT;

  typedef struct packed {
    logic [2:0] addrLanes;
    logic [2:0] dataLanes;
    logic       fourByte;
    logic [3:0] dummyClks;
  } modeT;

  typedef struct packed {
    logic       load;
    logic       shift;
    logic       sample;
    logic       done;
    logic [2:0] lanes;
    logic [LANES-1:0] oe;
  } strobeT;
endpackage

// File: rtl/flashSeqCtrl.sv
module flashSeqCtrl
  import flashSeqPkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   busy,
  input  modeT   mode,
  output strobeT strb,
  output logic   sck,
  output logic   csN
);
  phaseT phase;
  logic  half;
  logic [CW-1:0] cnt;
  logic [CW-1:0] addrLoad, dataLoad, dummyLoad;

  always_comb begin
    case (mode.addrLanes)
      3'd4:    addrLoad = mode.fourByte ? CW'(7)  : CW'(5);
      3'd2:    addrLoad = mode.fourByte ? CW'(15) : CW'(11);
      default: addrLoad = mode.fourByte ? CW'(31) : CW'(23);
    endcase
    case (mode.dataLanes)
      3'd4:    dataLoad = CW'(1);
      3'd2:    dataLoad = CW'(3);
      default: dataLoad = CW'(7);
    endcase
    dummyLoad = CW'(mode.dummyClks) - CW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      half  <= 1'b0;
      cnt   <= '0;
    end else if (phase == PH_IDLE) begin
      half <= 1'b0;
      if (busy) begin
        phase <= PH_CMD;
        cnt   <= CW'(7);
      end
    end else begin
      half <= ~half;
      if (half) begin
        if (cnt != '0) begin
          cnt <= cnt - CW'(1);
        end else begin
          case (phase)
            PH_CMD: begin
              phase <= PH_ADDR;
              cnt   <= addrLoad;
            end
            PH_ADDR: begin
              if (mode.dummyClks != 4'd0) begin
                phase <= PH_DUMMY;
                cnt   <= dummyLoad;
              end else begin
                phase <= PH_DATA;
                cnt   <= dataLoad;
              end
            end
            PH_DUMMY: begin
              phase <= PH_DATA;
              cnt   <= dataLoad;
            end
            default: phase <= PH_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    strb        = '0;
    strb.load   = (phase == PH_IDLE) && busy;
    strb.shift  = half && (phase == PH_CMD || phase == PH_ADDR);
    strb.sample = !half && (phase == PH_DATA);
    strb.done   = half && (phase == PH_DATA) && (cnt == '0);
    case (phase)
      PH_ADDR: strb.lanes = mode.addrLanes;
      PH_DATA: strb.lanes = mode.dataLanes;
      default: strb.lanes = 3'd1;
    endcase
    case (phase)
      PH_CMD:  strb.oe = 4'b0001;
      PH_ADDR: strb.oe = (mode.addrLanes == 3'd4) ? 4'b1111 :
                         (mode.addrLanes == 3'd2) ? 4'b0011 : 4'b0001;
      default: strb.oe = 4'b0000;
    endcase
  end

  assign sck = half;
  assign csN = (phase == PH_IDLE);

  // R5: the finishing strobe always follows a data sample by one clock
  a_r5_sample_before_done: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |-> $past(strb.sample));

  // R6: serial clock never high while deselected
  a_r6_sck_low_idle: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);
endmodule

// File: rtl/flashSeqData.sv
module flashSeqData
  import flashSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  strobeT            strb,
  input  logic [LANES-1:0]  sioIn,
  output logic [LANES-1:0]  sioOut,
  output logic              busy,
  output modeT              mode
);
  localparam int SH_W = 5 * BYTE_W;
  localparam int NADR = 4;

  logic [BYTE_W-1:0] adrB [NADR];
  logic [4:0]        busCfg;
  logic              fastRd;
  logic [BYTE_W-1:0] opc2, opc4, rdData, inSh, opcode;
  logic [SH_W-1:0]   outSh;

  always_comb begin
    mode.dataLanes = busCfg[2] ? 3'd4 : busCfg[0] ? 3'd2 : 3'd1;
    if (busCfg[2])      mode.addrLanes = busCfg[3] ? 3'd4 : 3'd1;
    else if (busCfg[0]) mode.addrLanes = busCfg[1] ? 3'd2 : 3'd1;
    else                mode.addrLanes = 3'd1;
    mode.fourByte = busCfg[4];
    if (mode.dataLanes == 3'd1)      mode.dummyClks = fastRd ? 4'd8 : 4'd0;
    else if (mode.addrLanes == 3'd1) mode.dummyClks = 4'd8;
    else if (mode.addrLanes == 3'd2) mode.dummyClks = 4'd4;
    else                             mode.dummyClks = 4'd6;
    opcode = busCfg[2] ? opc4 : busCfg[0] ? opc2 : (fastRd ? 8'h0B : 8'h03);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      busCfg <= '0;
      fastRd <= 1'b0;
      opc2   <= '0;
      opc4   <= '0;
      rdData <= '0;
    end else begin
      if (regWrEn && !busy) begin
        case (regAddr)
          OFS_CMD:  busy   <= regWrData[0];
          OFS_BUS:  busCfg <= regWrData[4:0];
          OFS_FAST: fastRd <= regWrData[0];
          OFS_OPC2: opc2   <= regWrData;
          OFS_OPC4: opc4   <= regWrData;
          default: ;
        endcase
      end
      if (strb.done) begin
        busy   <= 1'b0;
        rdData <= inSh;
      end
    end
  end

  for (genvar i = 0; i < NADR; i++) begin : gAdr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) adrB[i] <= '0;
      else if (regWrEn && !busy && regAddr == OFS_ADR0 + REG_AW'(i)) adrB[i] <= regWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSh <= '0;
      inSh  <= '0;
    end else begin
      if (strb.load)
        outSh <= mode.fourByte ? {opcode, adrB[3], adrB[2], adrB[1], adrB[0]}
                               : {opcode, adrB[2], adrB[1], adrB[0], 8'h00};
      else if (strb.shift)
        outSh <= outSh << strb.lanes;
      if (strb.sample) begin
        case (strb.lanes)
          3'd4:    inSh <= {inSh[3:0], sioIn[3:0]};
          3'd2:    inSh <= {inSh[5:0], sioIn[1:0]};
          default: inSh <= {inSh[6:0], sioIn[1]};
        endcase
      end
    end
  end

  always_comb begin
    case (strb.lanes)
      3'd4:    sioOut = outSh[SH_W-1 -: 4];
      3'd2:    sioOut = {2'b00, outSh[SH_W-1 -: 2]};
      default: sioOut = {3'b000, outSh[SH_W-1]};
    endcase
  end

  always_comb begin
    case (regAddr)
      OFS_CMD:   regRdData = {7'd0, busy};
      OFS_ADR0:  regRdData = adrB[0];
      OFS_ADR1:  regRdData = adrB[1];
      OFS_ADR2:  regRdData = adrB[2];
      OFS_ADR3:  regRdData = adrB[3];
      OFS_BUS:   regRdData = {3'd0, busCfg};
      OFS_FAST:  regRdData = {7'd0, fastRd};
      OFS_OPC2:  regRdData = opc2;
      OFS_OPC4:  regRdData = opc4;
      OFS_RDATA: regRdData = rdData;
      default:   regRdData = '0;
    endcase
  end

  // R6: start bit clears the clock after the byte is stored
  a_r6_self_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> !busy);

  // R8: configuration frozen while an access runs
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.done) |=> ($stable(busCfg) && $stable(adrB[0]) && $stable(adrB[3])
                              && $stable(opc2) && $stable(opc4) && $stable(fastRd)));
endmodule

// File: rtl/flashReadSeq.sv
module flashReadSeq
  import flashSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  output logic              sck,
  output logic              csN,
  inout  wire  [LANES-1:0]  sio
);
  strobeT          strb;
  modeT            mode;
  logic            busy;
  logic [LANES-1:0] sioOut;
  logic [LANES-1:0] sioIn;

  flashSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .busy(busy), .mode(mode),
    .strb(strb), .sck(sck), .csN(csN)
  );

  flashSeqData uData (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strb(strb),
    .sioIn(sioIn), .sioOut(sioOut), .busy(busy), .mode(mode)
  );

  for (genvar i = 0; i < LANES; i++) begin : gPad
    assign sio[i] = strb.oe[i] ? sioOut[i] : 1'bz;
  end
  assign sioIn = sio;

  // R7: no pad driven while data is being sampled
  a_r7_released: assert property (@(posedge clk) disable iff (!rstN)
    strb.sample |-> (strb.oe == 4'b0000));

  // R6: chip select only drops once an access is pending
  a_r6_cs_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> busy);
endmodule

// File: tb/sim_flashReadSeq.sv
`timescale 1ns/1ps
module sim_flashReadSeq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [3:0] regAddr = 4'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       sck, csN;
  wire  [3:0] sio;

  logic [3:0] fOut = 4'd0, fOe = 4'd0;
  int   checks = 0, errors = 0;
  bit   finished = 0;

  // flash model parameters set by the running test
  int fAl = 1, fDl = 1, fDummy = 0, fAdrBits = 24;
  logic [7:0] fByte = 8'h00;
  int riseCnt = 0, lastRises = 0;
  logic [7:0]  capOpc = 8'h00;
  logic [31:0] capAdr = 32'h0;

  always #5 clk = ~clk;

  for (genvar i = 0; i < 4; i++) begin : gDrv
    assign sio[i] = fOe[i] ? fOut[i] : 1'bz;
  end

  flashReadSeq u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sck(sck), .csN(csN), .sio(sio)
  );

  // behavioural flash device
  always @(posedge sck or negedge sck or posedge csN) begin
    int pre, k, chunk;
    logic [3:0] bits;
    if (csN) begin
      if (riseCnt != 0) lastRises = riseCnt;
      riseCnt = 0;
      fOe = 4'b0000;
    end else if (sck) begin
      riseCnt = riseCnt + 1;
      bits = sio;
      if (riseCnt <= 8) capOpc = {capOpc[6:0], bits[0]};
      else if (riseCnt <= 8 + fAdrBits / fAl) begin
        chunk = (fAl == 4) ? int'(bits) : (fAl == 2) ? int'(bits[1:0]) : int'(bits[0]);
        if (riseCnt == 9) capAdr = 32'(chunk);
        else capAdr = (capAdr << fAl) | 32'(chunk);
      end
    end else begin
      pre = 8 + fAdrBits / fAl + fDummy;
      k = riseCnt - pre;
      if (k >= 0 && k < 8 / fDl) begin
        chunk = (int'(fByte) >> (8 - fDl * (k + 1))) & ((1 << fDl) - 1);
        if (fDl == 1) begin fOut = {2'b00, chunk[0], 1'b0}; fOe = 4'b0010; end
        else if (fDl == 2) begin fOut = {2'b00, chunk[1:0]}; fOe = 4'b0011; end
        else begin fOut = chunk[3:0]; fOe = 4'b1111; end
      end else begin
        fOe = 4'b0000;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 4'd0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
    regAddr = 4'd0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // one complete read; poke != 0 attempts a write to address byte 0 mid-transfer
  task automatic doRead(input string tag, input logic [4:0] bus, input bit fast,
                        input logic [31:0] adr, input logic [7:0] o2, input logic [7:0] o4,
                        input logic [7:0] dataByte, input bit poke);
    int dl, al, dum, n, seqErr;
    bit fb;
    logic [7:0] expOpc, rb;
    logic [31:0] expAdr;
    dl = bus[2] ? 4 : bus[0] ? 2 : 1;
    al = bus[2] ? (bus[3] ? 4 : 1) : bus[0] ? (bus[1] ? 2 : 1) : 1;
    fb = bus[4];
    if (dl == 1) dum = fast ? 8 : 0;
    else dum = (al == 1) ? 8 : (al == 2) ? 4 : 6;
    expOpc = bus[2] ? o4 : bus[0] ? o2 : (fast ? 8'h0B : 8'h03);
    expAdr = fb ? adr : {8'h00, adr[23:0]};
    n = 8 + (fb ? 32 : 24) / al + dum + 8 / dl;

    regWrite(4'd1, adr[7:0]);
    regWrite(4'd2, adr[15:8]);
    regWrite(4'd3, adr[23:16]);
    regWrite(4'd4, adr[31:24]);
    regWrite(4'd5, {3'b000, bus});
    regWrite(4'd6, {7'd0, fast});
    regWrite(4'd7, o2);
    regWrite(4'd8, o4);
    fAl = al; fDl = dl; fDummy = dum; fAdrBits = fb ? 32 : 24; fByte = dataByte;

    regWrite(4'd0, 8'h01);
    // cycle-by-cycle reference: j = edges since the start write
    seqErr = 0;
    for (int j = 0; j <= 2 * n + 1; j++) begin
      logic expBusy, expCs, expSck;
      if (j > 0) @(negedge clk);
      if (poke && j == 5) begin regAddr = 4'd1; regWrData = ~adr[7:0]; regWrEn = 1'b1; end
      else if (poke && j == 6) begin regWrEn = 1'b0; regAddr = 4'd0; end
      if (!(poke && j == 5)) begin
        expBusy = (j <= 2 * n);
        expCs   = !(j >= 1 && j <= 2 * n);
        expSck  = (j >= 2 && j <= 2 * n && (j % 2 == 0));
        #1;
        if (regAddr == 4'd0 && regRdData[0] !== expBusy) seqErr++;
        if (csN !== expCs || sck !== expSck) seqErr++;
      end
    end
    check({tag, " R6 busy/csN/sck sequence mismatches"}, 32'(seqErr), 32'd0);
    check({tag, " R2 opcode"}, {24'd0, capOpc}, {24'd0, expOpc});
    check({tag, " R3 address"}, capAdr, expAdr);
    check({tag, " R4 SCK period count"}, 32'(lastRises), 32'(n));
    regRead(4'd9, rb);
    check({tag, " R5 read data"}, {24'd0, rb}, {24'd0, dataByte});
    if (poke) begin
      regRead(4'd1, rb);
      check({tag, " R8 write during access ignored"}, {24'd0, rb}, {24'd0, adr[7:0]});
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] rb;
    repeat (3) @(posedge clk);
    // R1: reset state
    #1;
    check("R1 csN at reset", {31'd0, csN}, 32'd1);
    check("R1 sck at reset", {31'd0, sck}, 32'd0);
    for (int a = 0; a < 10; a++) begin
      regRead(4'(a), rb);
      check("R1 register zero at reset", {24'd0, rb}, 32'd0);
    end
    rstN = 1'b1;
    repeat (2) @(posedge clk);

    doRead("plain",       5'b00000, 1'b0, 32'h00A1B2C3, 8'h3B, 8'h6B, 8'h5A, 1'b0);
    doRead("fast3",       5'b00000, 1'b1, 32'h00123456, 8'h3B, 8'h6B, 8'hC3, 1'b0);
    doRead("fast4",       5'b10000, 1'b1, 32'hDEADBEEF, 8'h3B, 8'h6B, 8'h81, 1'b0);
    doRead("dualA1",      5'b00001, 1'b0, 32'h00654321, 8'h3B, 8'h6B, 8'h96, 1'b0);
    doRead("dualA2",      5'b00011, 1'b0, 32'h00F0E1D2, 8'hBB, 8'hEB, 8'h3C, 1'b0);
    doRead("quadA1",      5'b00100, 1'b0, 32'h00ABCDEF, 8'h3B, 8'h6B, 8'hE7, 1'b0);
    doRead("quadA4x4",    5'b11100, 1'b0, 32'h89ABCDEF, 8'h3B, 8'hEC, 8'h1F, 1'b0);
    // R2 priority: both data-width bits set, fast set too -> four-lane opcode wins
    doRead("bothWidths",  5'b00101, 1'b1, 32'h00112233, 8'h3B, 8'h6C, 8'hA5, 1'b0);
    // R3: lane bit for address without its data bit stays single-lane
    doRead("addrBitOnly", 5'b01010, 1'b0, 32'h00778899, 8'h3B, 8'h6B, 8'h42, 1'b0);
    doRead("pokeDuring",  5'b00000, 1'b1, 32'h00445566, 8'h3B, 8'h6B, 8'h69, 1'b1);

    // R9: command write with bit 0 clear starts nothing
    regWrite(4'd0, 8'hFE);
    repeat (4) @(negedge clk);
    #1;
    check("R9 csN stays high", {31'd0, csN}, 32'd1);
    regRead(4'd0, rb);
    check("R9 start bit stays clear", {24'd0, rb}, 32'd0);

    summary();
  end
endmodule